// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block sits next to a floating-point datapath. For a two-input operation whose result has to be a NaN, it chooses which operand's NaN goes out, makes that NaN quiet, and reports whether the invalid-operation flag must be raised. It looks only at the two operand encodings and three controls. It does not do the arithmetic, and it does not decide whether a NaN result is needed.

The caller can force every NaN result to the canonical default NaN. It can choose between two selection policies: a fixed operand order, or a comparison of magnitudes. It can also choose which encoding of the top fraction bit marks a quiet NaN. The format width is a parameter (32 or 64). A second parameter decides whether the outputs are registered (one cycle of latency) or taken straight from the combinational path.

Top module: `nanp_sel`

## Requirements
- R1: When `dflt_mode` is 1 and at least one operand is a NaN, `nan_out` is the default NaN and `invalid` is 0, whatever the operands and the policy.
- R2: When `dflt_mode` is 0 and at least one operand is a NaN, `invalid` is 1 exactly when at least one operand is a signalling NaN.
- R3: Classification uses an all-ones exponent field. With `inv_pol`=0, a NaN is quiet when the fraction MSB (bit 22 for 32-bit, bit 51 for 64-bit) is 1. It is signalling when that bit is 0 and some lower fraction bit is 1. With `inv_pol`=1 the quiet and signalling tests swap roles. An all-ones exponent with a zero fraction is not a NaN.
- R4: With `policy_sel`=0 the chosen operand is the first match in this list: A if signalling, B if signalling, A if quiet, otherwise B.
- R5: With `policy_sel`=1: if one operand is signalling and the other is quiet, the quiet one is chosen. If only one operand is a NaN, that operand is chosen.
- R6: With `policy_sel`=1 and both operands of the same NaN kind, the operand with the larger magnitude is chosen. Magnitude is the encoding without its sign bit, read as an unsigned number. On equal magnitudes the operand whose sign bit is 0 is chosen, and B is chosen if both signs match.
- R7: With `inv_pol`=0, a chosen signalling NaN is output with its fraction MSB set and every other bit unchanged. A chosen quiet NaN is output unchanged.
- R8: With `inv_pol`=1, a chosen signalling NaN is replaced by the default NaN of that polarity.
- R9: The default NaN for 32-bit is 0x7FC00000 (`inv_pol`=0) or 0x7FBFFFFF (`inv_pol`=1). For 64-bit it is 0x7FF8000000000000 or 0x7FF7FFFFFFFFFFFF.
- R10: When neither operand is a NaN, `no_nan` is 1, `nan_out` equals `op_b` and `invalid` is 0, in every mode. Otherwise `no_nan` is 0.
- R11: With `REG_OUT`=1 (the default), the outputs take the value for the inputs present at a rising clock edge and keep it until the next edge. A synchronous `rst` clears all outputs to 0. With `REG_OUT`=0 the outputs follow the inputs combinationally.
- R12: With `WIDTH`=64 the exponent field is bits 62:52 and the fraction MSB is bit 51. All the rules above apply to that layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | First operand encoding |
| op_b | input | WIDTH | Second operand encoding |
| dflt_mode | input | 1 | 1 forces the default NaN as the result |
| policy_sel | input | 1 | 0 selects by operand order, 1 selects by magnitude |
| inv_pol | input | 1 | 1 selects the inverted quiet-bit encoding |
| nan_out | output | WIDTH | Selected and quieted NaN, or op_b when neither operand is a NaN |
| invalid | output | 1 | Invalid-operation flag |
| no_nan | output | 1 | 1 when neither operand is a NaN |

## Verification
With the default registered outputs, every result (`nan_out`, `invalid`, `no_nan`) is due one rising edge after the inputs that produce it. The bench therefore drives on a falling edge and compares on the next falling edge. Before that edge it also samples once, 1 ns after driving, to confirm that the outputs still hold the previous result. A second instance is built with 64-bit width and no output register. Its results are due in the same cycle, so the bench samples them 1 ns after driving.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    typedef enum logic {
        POLICY_ORDER = 1'b0,
        POLICY_MAG   = 1'b1
    } policy_e;

    typedef struct packed {
        logic quiet;
        logic sig;
    } nan_cls_t;

    function automatic int exp_bits(input int w);
        return (w == 64) ? 11 : 8;
    endfunction

    function automatic int frac_bits(input int w);
        return w - 1 - exp_bits(w);
    endfunction

    function automatic logic cls_is_nan(input nan_cls_t c);
        return c.quiet | c.sig;
    endfunction

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-2:0] body,
    input  logic             inv_pol,
    output nan_cls_t         cls
);
    localparam int FRACW = frac_bits(WIDTH);

    logic exp_full;
    logic top_bit;
    logic low_any;
    logic std_quiet;
    logic std_sig;

    always_comb begin
        exp_full  = &body[WIDTH-2:FRACW];
        top_bit   = body[FRACW-1];
        low_any   = |body[FRACW-2:0];
        std_quiet = exp_full & top_bit;
        std_sig   = exp_full & ~top_bit & low_any;
        cls.quiet = inv_pol ? std_sig   : std_quiet;
        cls.sig   = inv_pol ? std_quiet : std_sig;
    end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  nan_cls_t         cls_a,
    input  nan_cls_t         cls_b,
    input  logic [WIDTH-2:0] body_a,
    input  logic [WIDTH-2:0] body_b,
    input  logic             sign_a,
    input  logic             sign_b,
    input  policy_e          policy,
    output pick_e            pick
);
    logic  a_gt;
    logic  b_gt;
    logic  a_larger;
    pick_e ord_pick;
    pick_e mag_pick;

    always_comb begin
        a_gt     = body_a > body_b;
        b_gt     = body_b > body_a;
        a_larger = a_gt | (~b_gt & ~sign_a & sign_b);

        if (cls_a.sig)        ord_pick = PICK_A;
        else if (cls_b.sig)   ord_pick = PICK_B;
        else if (cls_a.quiet) ord_pick = PICK_A;
        else                  ord_pick = PICK_B;

        if (cls_a.sig) begin
            if (cls_b.sig)        mag_pick = a_larger ? PICK_A : PICK_B;
            else if (cls_b.quiet) mag_pick = PICK_B;
            else                  mag_pick = PICK_A;
        end else if (cls_a.quiet) begin
            if (cls_b.sig || !cls_b.quiet) mag_pick = PICK_A;
            else                           mag_pick = a_larger ? PICK_A : PICK_B;
        end else begin
            mag_pick = PICK_B;
        end

        pick = (policy == POLICY_MAG) ? mag_pick : ord_pick;
    end
endmodule

// File: rtl/nanp_quiet.sv
module nanp_quiet
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] chosen,
    input  logic             chosen_sig,
    input  logic             inv_pol,
    output logic [WIDTH-1:0] quieted,
    output logic [WIDTH-1:0] dflt_nan
);
    localparam int EXPW = exp_bits(WIDTH);
    localparam int FRACW = frac_bits(WIDTH);
    localparam logic [WIDTH-1:0] EXP_ONES = ((WIDTH'(1) << EXPW) - WIDTH'(1)) << FRACW;
    localparam logic [WIDTH-1:0] QBIT = WIDTH'(1) << (FRACW - 1);

    always_comb begin
        dflt_nan = inv_pol ? (EXP_ONES | (QBIT - WIDTH'(1))) : (EXP_ONES | QBIT);
        if (!chosen_sig)  quieted = chosen;
        else if (inv_pol) quieted = dflt_nan;
        else              quieted = chosen | QBIT;
    end
endmodule

// File: rtl/nanp_sel.sv
module nanp_sel
    import nanp_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             dflt_mode,
    input  logic             policy_sel,
    input  logic             inv_pol,
    output logic [WIDTH-1:0] nan_out,
    output logic             invalid,
    output logic             no_nan
);
    logic [WIDTH-1:0] opnd [2];
    nan_cls_t         cls  [2];
    pick_e            pick;
    logic [WIDTH-1:0] chosen;
    logic             chosen_sig;
    logic [WIDTH-1:0] quieted;
    logic [WIDTH-1:0] dflt_nan;
    logic             any_nan;
    logic             any_sig;
    logic [WIDTH-1:0] c_res;
    logic             c_inv;
    logic             c_err;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        nanp_classify #(.WIDTH(WIDTH)) u_cls (
            .body    (opnd[g][WIDTH-2:0]),
            .inv_pol (inv_pol),
            .cls     (cls[g])
        );
    end

    nanp_pick #(.WIDTH(WIDTH)) u_pick (
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .body_a (op_a[WIDTH-2:0]),
        .body_b (op_b[WIDTH-2:0]),
        .sign_a (op_a[WIDTH-1]),
        .sign_b (op_b[WIDTH-1]),
        .policy (policy_e'(policy_sel)),
        .pick   (pick)
    );

    always_comb begin
        chosen     = (pick == PICK_B) ? op_b : op_a;
        chosen_sig = (pick == PICK_B) ? cls[1].sig : cls[0].sig;
    end

    nanp_quiet #(.WIDTH(WIDTH)) u_quiet (
        .chosen     (chosen),
        .chosen_sig (chosen_sig),
        .inv_pol    (inv_pol),
        .quieted    (quieted),
        .dflt_nan   (dflt_nan)
    );

    always_comb begin
        any_nan = cls_is_nan(cls[0]) | cls_is_nan(cls[1]);
        any_sig = cls[0].sig | cls[1].sig;
        c_err   = ~any_nan;
        c_inv   = any_nan & ~dflt_mode & any_sig;
        if (!any_nan)       c_res = op_b;
        else if (dflt_mode) c_res = dflt_nan;
        else                c_res = quieted;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                nan_out <= '0;
                invalid <= 1'b0;
                no_nan  <= 1'b0;
            end else begin
                nan_out <= c_res;
                invalid <= c_inv;
                no_nan  <= c_err;
            end
        end
    end else begin : g_comb
        assign nan_out = c_res;
        assign invalid = c_inv;
        assign no_nan  = c_err;
    end
endmodule

// File: rtl/nanp_sel_chk.sv
module nanp_sel_chk #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_b,
    input logic             dflt_mode,
    input logic             inv_pol,
    input logic [WIDTH-1:0] c_res,
    input logic             c_inv,
    input logic             c_err,
    input logic [WIDTH-1:0] nan_out,
    input logic             invalid,
    input logic             no_nan
);
    localparam int FRACW = (WIDTH == 64) ? 52 : 23;
    localparam logic [63:0] DN_STD = (WIDTH == 64) ? 64'h7FF8000000000000 : 64'h000000007FC00000;
    localparam logic [63:0] DN_INV = (WIDTH == 64) ? 64'h7FF7FFFFFFFFFFFF : 64'h000000007FBFFFFF;

    logic [WIDTH-1:0] exp_dn;
    logic             res_quiet;

    always_comb begin
        exp_dn    = inv_pol ? DN_INV[WIDTH-1:0] : DN_STD[WIDTH-1:0];
        res_quiet = (&c_res[WIDTH-2:FRACW]) &&
                    (inv_pol ? (!c_res[FRACW-1] && (|c_res[FRACW-2:0])) : c_res[FRACW-1]);
    end

    AST_DFLT_VALUE: assert property (@(posedge clk) disable iff (rst)
        (dflt_mode && !c_err) |-> (c_res == exp_dn));              // R1
    AST_DFLT_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        dflt_mode |-> !c_inv);                                     // R1
    AST_FLAG_NEEDS_NAN: assert property (@(posedge clk) disable iff (rst)
        c_inv |-> !c_err);                                         // R2
    AST_OUT_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!dflt_mode && !c_err) |-> res_quiet);                     // R7
    AST_NO_NAN_PASS: assert property (@(posedge clk) disable iff (rst)
        c_err |-> (c_res == op_b && !c_inv));                      // R10

    if (REG_OUT) begin : g_reg_chk
        AST_REG_STAGE: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (nan_out == $past(c_res) && invalid == $past(c_inv)
                             && no_nan == $past(c_err)));          // R11
    end
endmodule

bind nanp_sel nanp_sel_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_b      (op_b),
    .dflt_mode (dflt_mode),
    .inv_pol   (inv_pol),
    .c_res     (c_res),
    .c_inv     (c_inv),
    .c_err     (c_err),
    .nan_out   (nan_out),
    .invalid   (invalid),
    .no_nan    (no_nan)
);

// File: tb/nanp_sel_tb.sv
`timescale 1ns/1ps
module nanp_sel_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [31:0] a32 = '0, b32 = '0, res32;
    logic        dm32 = 0, pm32 = 0, ip32 = 0, inv32, err32;
    logic [63:0] a64 = '0, b64 = '0, res64;
    logic        dm64 = 0, pm64 = 0, ip64 = 0, inv64, err64;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    nanp_sel u_dut (
        .clk(clk), .rst(rst), .op_a(a32), .op_b(b32), .dflt_mode(dm32),
        .policy_sel(pm32), .inv_pol(ip32), .nan_out(res32), .invalid(inv32), .no_nan(err32)
    );

    nanp_sel #(.WIDTH(64), .REG_OUT(1'b0)) u_dut64 (
        .clk(clk), .rst(rst), .op_a(a64), .op_b(b64), .dflt_mode(dm64),
        .policy_sel(pm64), .inv_pol(ip64), .nan_out(res64), .invalid(inv64), .no_nan(err64)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        dm;
        logic        pm;
        logic        ip;
        logic [31:0] er;
        logic        ei;
        logic        ee;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{32'h7F800005, 32'h7FC00002, 1'b0, 1'b0, 1'b0, 32'h7FC00005, 1'b1, 1'b0, 4'd4},  // R4 R7
        '{32'h7FC00001, 32'h7F800100, 1'b0, 1'b0, 1'b0, 32'h7FC00100, 1'b1, 1'b0, 4'd4},  // R4 R2
        '{32'h7FC00001, 32'h7FC00002, 1'b0, 1'b0, 1'b0, 32'h7FC00001, 1'b0, 1'b0, 4'd4},  // R4
        '{32'h3F800000, 32'h7FC00002, 1'b0, 1'b0, 1'b0, 32'h7FC00002, 1'b0, 1'b0, 4'd4},  // R4
        '{32'hFFC00003, 32'h3F800000, 1'b0, 1'b0, 1'b0, 32'hFFC00003, 1'b0, 1'b0, 4'd4},  // R4
        '{32'h7F800005, 32'h7FC00002, 1'b0, 1'b1, 1'b0, 32'h7FC00002, 1'b1, 1'b0, 4'd5},  // R5
        '{32'h7FC00001, 32'h7F800100, 1'b0, 1'b1, 1'b0, 32'h7FC00001, 1'b1, 1'b0, 4'd5},  // R5
        '{32'h7FC00001, 32'h7FC00002, 1'b0, 1'b1, 1'b0, 32'h7FC00002, 1'b0, 1'b0, 4'd6},  // R6
        '{32'h7F800200, 32'h7F800100, 1'b0, 1'b1, 1'b0, 32'h7FC00200, 1'b1, 1'b0, 4'd6},  // R6 R7
        '{32'hFFC00004, 32'h7FC00004, 1'b0, 1'b1, 1'b0, 32'h7FC00004, 1'b0, 1'b0, 4'd6},  // R6 tie
        '{32'h7FC00004, 32'hFFC00004, 1'b0, 1'b1, 1'b0, 32'h7FC00004, 1'b0, 1'b0, 4'd6},  // R6 tie
        '{32'h3F800000, 32'h7F800100, 1'b0, 1'b1, 1'b0, 32'h7FC00100, 1'b1, 1'b0, 4'd5},  // R5
        '{32'hFFC00001, 32'h7FC00002, 1'b0, 1'b1, 1'b0, 32'h7FC00002, 1'b0, 1'b0, 4'd6},  // R6
        '{32'h7F800005, 32'h7FC00002, 1'b1, 1'b0, 1'b0, 32'h7FC00000, 1'b0, 1'b0, 4'd1},  // R1 R9
        '{32'h7FC00001, 32'h3F800000, 1'b1, 1'b1, 1'b1, 32'h7FBFFFFF, 1'b0, 1'b0, 4'd1},  // R1 R9
        '{32'h7FC00000, 32'h7F800001, 1'b0, 1'b0, 1'b1, 32'h7FBFFFFF, 1'b1, 1'b0, 4'd3},  // R3 R8
        '{32'h7F800001, 32'h7F800002, 1'b0, 1'b0, 1'b1, 32'h7F800001, 1'b0, 1'b0, 4'd3},  // R3
        '{32'h7FC00000, 32'h7F800003, 1'b0, 1'b1, 1'b1, 32'h7F800003, 1'b1, 1'b0, 4'd3},  // R3 R5
        '{32'h3F800000, 32'h40000000, 1'b0, 1'b0, 1'b0, 32'h40000000, 1'b0, 1'b1, 4'd10}, // R10
        '{32'h7F800000, 32'hFF800000, 1'b0, 1'b1, 1'b0, 32'hFF800000, 1'b0, 1'b1, 4'd10}, // R10 R3
        '{32'h3F800000, 32'h40000000, 1'b1, 1'b0, 1'b1, 32'h40000000, 1'b0, 1'b1, 4'd10}, // R10
        '{32'h7FC00001, 32'h3F800000, 1'b0, 1'b0, 1'b1, 32'h7FBFFFFF, 1'b1, 1'b0, 4'd8},  // R8
        '{32'h7F800001, 32'hFF800009, 1'b0, 1'b1, 1'b1, 32'hFF800009, 1'b0, 1'b0, 4'd6}   // R6
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive64(input logic [63:0] a, input logic [63:0] b,
                           input logic dm, input logic pm, input logic ip);
        a64 = a; b64 = b; dm64 = dm; pm64 = pm; ip64 = ip;
        #1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11: watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset nan_out", 64'(res32), 64'h0);
        chk("R11 reset invalid", 64'(inv32), 64'h0);
        chk("R11 reset no_nan", 64'(err32), 64'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a32 = VECS[i].a; b32 = VECS[i].b;
            dm32 = VECS[i].dm; pm32 = VECS[i].pm; ip32 = VECS[i].ip;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d nan_out", VECS[i].rq, i), 64'(res32), 64'(VECS[i].er));
            chk($sformatf("R%0d vec%0d invalid", VECS[i].rq, i), 64'(inv32), 64'(VECS[i].ei));
            chk($sformatf("R%0d vec%0d no_nan", VECS[i].rq, i), 64'(err32), 64'(VECS[i].ee));
        end

        // R11: registered output holds until the next rising edge
        a32 = VECS[0].a; b32 = VECS[0].b;
        dm32 = VECS[0].dm; pm32 = VECS[0].pm; ip32 = VECS[0].ip;
        #1;
        chk("R11 hold before edge", 64'(res32), 64'h00000000FF800009);
        @(negedge clk);
        chk("R11 update after edge", 64'(res32), 64'h000000007FC00005);

        // R12: 64-bit layout, combinational instance
        drive64(64'h7FF0000000000001, 64'h7FF8000000000002, 1'b0, 1'b0, 1'b0);
        chk("R12 R7 64b silence", res64, 64'h7FF8000000000001);
        chk("R12 R2 64b invalid", 64'(inv64), 64'h1);
        drive64(64'h7FF0000000000001, 64'h7FF8000000000002, 1'b1, 1'b0, 1'b0);
        chk("R9 64b default std", res64, 64'h7FF8000000000000);
        drive64(64'h7FF0000000000001, 64'h7FF8000000000002, 1'b1, 1'b0, 1'b1);
        chk("R9 64b default inv", res64, 64'h7FF7FFFFFFFFFFFF);
        drive64(64'h7FF8000000000010, 64'hFFF8000000000020, 1'b0, 1'b1, 1'b0);
        chk("R6 R12 64b magnitude", res64, 64'hFFF8000000000020);
        drive64(64'h7FF8000000000000, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b1);
        chk("R8 R12 64b inverted", res64, 64'h7FF7FFFFFFFFFFFF);
        chk("R8 R12 64b inverted flag", 64'(inv64), 64'h1);
        drive64(64'h3FF0000000000000, 64'h4000000000000000, 1'b0, 1'b1, 1'b0);
        chk("R10 R12 64b no nan", 64'(err64), 64'h1);
        chk("R10 R12 64b pass b", res64, 64'h4000000000000000);

        // R11: synchronous reset clears the register again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 mid-run reset", 64'(res32), 64'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule